// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of an open-drain, wired-AND two-wire bus. Other logic in the chip uses it to learn when a transfer opens or closes, whether the bus is in use, and when it may try to claim the bus. Each line passes through a two-flop synchronizer and a run-length glitch filter. Edge detection works only on the filtered levels. A start or stop condition gives a single-cycle pulse and sets or clears a busy flag. A timer reports the bus as free once both lines have stayed high for a threshold that depends on the speed mode. The threshold is given in clock cycles, one parameter per mode.

The block also compares what the local node drives with what it sees on the lines. The node becomes engaged when it pulls either line low. From then until the next stop condition, the block watches each line the node has released. A line counts as released once its drive has been off long enough for the sync and filter latency to pass. If such a line still reads low, another device is holding it, and the block gives one arbitration-lost pulse. The block then ignores further drive activity until a stop condition is seen.

The block has no data stream, so every pin is a plain level or pulse.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling filtered data level while the filtered clock is high, and was high on the previous sample, gives exactly one single-cycle `start_pulse`.
- R2: A rising filtered data level while the filtered clock is high, and was high on the previous sample, gives exactly one single-cycle `stop_pulse`. A start pulse and a stop pulse never occur together.
- R3: `bus_busy` rises together with every start pulse and falls together with every stop pulse. A repeated start while busy gives a new start pulse and leaves busy high.
- R4: Data changes made while the clock is low produce neither a start pulse nor a stop pulse.
- R5: With `fast_mode`=0, `bus_free` goes high only after both filtered lines have been high for `IDLE_STD_CYC` consecutive cycles.
- R6: With `fast_mode`=1, the threshold is `IDLE_FAST_CYC` cycles, so the bus is reported free sooner than in standard mode.
- R7: A low level on either line restarts the idle count and drops `bus_free` at once. This includes a clock-only low pulse.
- R8: A line excursion shorter than `FILT_LEN` cycles is ignored. An excursion of `FILT_LEN` cycles or more is accepted.
- R9: While engaged, a line whose drive enable has been off for at least the settle time and which still reads low gives one `arb_lost` pulse. Further drive activity is ignored until the next stop condition.
- R10: `arb_lost` stays low when a released line reads high, and when the node has not driven since the last stop condition. This holds even when another device pulls data low.
- R11: During and right after reset, `start_pulse`, `stop_pulse`, `bus_busy`, `bus_free` and `arb_lost` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| scl_drive_low | input | 1 | Local node pulls the clock line low |
| sda_drive_low | input | 1 | Local node pulls the data line low |
| fast_mode | input | 1 | 1 selects the fast-mode idle threshold, 0 the standard one |
| start_pulse | output | 1 | One-cycle pulse on a start condition |
| stop_pulse | output | 1 | One-cycle pulse on a stop condition |
| bus_busy | output | 1 | High from a start condition until a stop condition |
| bus_free | output | 1 | Both lines have been high for the selected idle threshold |
| arb_lost | output | 1 | One-cycle pulse when a released line is held low by another device |

## Verification
The hardest state to reach is a real arbitration loss. The node must first engage by driving, then release data and let the settle window run out, while another device keeps data low. The bench models the wired-AND lines and steps through this: the node issues its own start, pulls the clock low, releases data with the line high (no loss expected), toggles the clock, and only then has another master hold data low. After that it holds the same inputs for a second interval to show the pulse does not repeat. Two-cycle and three-cycle glitches, and a clock-only low pulse on an idle bus, reach the filter and idle-restart corners.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;

  localparam int SYNC_STAGES = 2;
  localparam int SETTLE_MARGIN = 2;
endpackage

// File: rtl/i2cm_line_filter.sv
module i2cm_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

  logic [i2c_mon_pkg::SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] run_q;
  logic synced;

  assign synced = sync_q[i2c_mon_pkg::SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      run_q  <= '0;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[i2c_mon_pkg::SYNC_STAGES-2:0], raw};
      if (synced != filt) begin
        if (run_q == RUN_LAST) begin
          filt  <= synced;
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cm_cond_detect.sv
module i2cm_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t lines,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       busy
);
  line_pair_t prev_q;
  logic start_c, stop_c;

  assign start_c = lines.scl & prev_q.scl & prev_q.sda & ~lines.sda;
  assign stop_c  = lines.scl & prev_q.scl & ~prev_q.sda & lines.sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '1;
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      busy        <= 1'b0;
    end else begin
      prev_q      <= lines;
      start_pulse <= start_c;
      stop_pulse  <= stop_c;
      if (start_c)     busy <= 1'b1;
      else if (stop_c) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_idle_timer.sv
module i2cm_idle_timer
  import i2c_mon_pkg::*;
#(
  parameter int IDLE_STD_CYC  = 235,
  parameter int IDLE_FAST_CYC = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t lines,
  input  logic       fast_mode,
  output logic       bus_free
);
  localparam int MAX_CYC = (IDLE_STD_CYC > IDLE_FAST_CYC) ? IDLE_STD_CYC : IDLE_FAST_CYC;
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] THR_STD  = CW'(IDLE_STD_CYC);
  localparam logic [CW-1:0] THR_FAST = CW'(IDLE_FAST_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;

  assign thr = fast_mode ? THR_FAST : THR_STD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!(lines.scl & lines.sda)) begin
      cnt_q <= '0;
    end else if (cnt_q < thr) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bus_free = (cnt_q >= thr);
endmodule

// File: rtl/i2cm_arb_check.sv
module i2cm_arb_check
  import i2c_mon_pkg::*;
#(
  parameter int SETTLE = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_pair_t lines,
  input  line_pair_t drive,
  input  logic       stop_seen,
  output logic       arb_lost
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

  logic [1:0] rel_ok;
  logic [1:0] drv_bits, line_bits;
  logic engaged_q, locked_q, lost_c;

  assign drv_bits  = drive;
  assign line_bits = lines;

  for (genvar i = 0; i < 2; i++) begin : g_settle
    logic [SW-1:0] rel_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rel_cnt_q <= '0;
      else if (drv_bits[i])          rel_cnt_q <= '0;
      else if (rel_cnt_q != SETTLE_V) rel_cnt_q <= rel_cnt_q + 1'b1;
    end
    assign rel_ok[i] = (rel_cnt_q == SETTLE_V);
  end

  assign lost_c = engaged_q & |(rel_ok & ~line_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      engaged_q <= 1'b0;
      locked_q  <= 1'b0;
      arb_lost  <= 1'b0;
    end else begin
      arb_lost <= lost_c;
      if (stop_seen) begin
        engaged_q <= 1'b0;
        locked_q  <= 1'b0;
      end else if (lost_c) begin
        engaged_q <= 1'b0;
        locked_q  <= 1'b1;
      end else if (|drv_bits && !locked_q) begin
        engaged_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int FILT_LEN      = 3,
  parameter int IDLE_STD_CYC  = 235,
  parameter int IDLE_FAST_CYC = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic scl_drive_low,
  input  logic sda_drive_low,
  input  logic fast_mode,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bus_busy,
  output logic bus_free,
  output logic arb_lost
);
  localparam int SETTLE = SYNC_STAGES + FILT_LEN + SETTLE_MARGIN;

  line_pair_t raw_v, filt_v, drive_v;
  logic [1:0] raw_bits, filt_bits;

  assign raw_v   = '{scl: scl_i, sda: sda_i};
  assign drive_v = '{scl: scl_drive_low, sda: sda_drive_low};
  assign raw_bits = raw_v;
  assign filt_v   = filt_bits;

  for (genvar i = 0; i < 2; i++) begin : g_line
    i2cm_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_bits[i]),
      .filt (filt_bits[i])
    );
  end

  i2cm_cond_detect u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines      (filt_v),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .busy       (bus_busy)
  );

  i2cm_idle_timer #(
    .IDLE_STD_CYC (IDLE_STD_CYC),
    .IDLE_FAST_CYC(IDLE_FAST_CYC)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (filt_v),
    .fast_mode(fast_mode),
    .bus_free (bus_free)
  );

  i2cm_arb_check #(.SETTLE(SETTLE)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (filt_v),
    .drive    (drive_v),
    .stop_seen(stop_pulse),
    .arb_lost (arb_lost)
  );
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bus_busy,
  input logic bus_free,
  input logic arb_lost
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R1
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> !stop_pulse); // R2
  AST_NO_DUAL_COND: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse)); // R2
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> bus_busy); // R3
  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !bus_busy); // R3
  AST_NOT_FREE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !bus_free); // R7
  AST_ARB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost); // R9
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_pulse(start_pulse),
  .stop_pulse (stop_pulse),
  .bus_busy   (bus_busy),
  .bus_free   (bus_free),
  .arb_lost   (arb_lost)
);

// File: tb/tb_i2c_bus_monitor.sv
module tb_i2c_bus_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 3;
  localparam int THR_STD = 40;
  localparam int THR_FAST = 16;

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic       scl_dl;
    logic       sda_dl;
    logic       fast;
    logic [7:0] hold;
    logic [1:0] es;
    logic [1:0] ep;
    logic       eb;
    logic       ef;
    logic [1:0] ea;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  // scl sda scl_dl sda_dl fast hold starts stops busy free arbs req
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,0,50,0,0,0,1,0,5},   // R5 idle after reset
    '{1,0,0,0,0,12,1,0,1,0,0,1},   // R1 external start, R10 not engaged
    '{0,0,0,0,0,12,0,0,1,0,0,4},
    '{0,1,0,0,0,12,0,0,1,0,0,4},   // R4 data rise with clock low
    '{1,1,0,0,0,12,0,0,1,0,0,3},
    '{0,1,0,0,0,12,0,0,1,0,0,4},
    '{0,0,0,0,0,12,0,0,1,0,0,4},   // R4 data fall with clock low
    '{1,0,0,0,0,12,0,0,1,0,0,3},
    '{1,1,0,0,0,12,0,1,0,0,0,2},   // R2 stop
    '{1,1,0,0,0,40,0,0,0,1,0,5},   // R5 standard threshold met
    '{1,0,0,0,1,12,1,0,1,0,0,1},
    '{0,0,0,0,1,12,0,0,1,0,0,3},
    '{0,1,0,0,1,12,0,0,1,0,0,3},
    '{1,1,0,0,1,12,0,0,1,0,0,3},
    '{1,0,0,0,1,12,1,0,1,0,0,3},   // R3 repeated start
    '{0,0,0,0,1,12,0,0,1,0,0,3},
    '{1,0,0,0,1,12,0,0,1,0,0,3},
    '{1,1,0,0,1,12,0,1,0,0,0,6},
    '{1,1,0,0,1,14,0,0,0,1,0,6},   // R6 fast threshold met
    '{1,1,0,1,1,12,1,0,1,0,0,10},  // node start
    '{1,1,1,1,1,12,0,0,1,0,0,10},
    '{1,1,1,0,1,12,0,0,1,0,0,10},  // R10 released data reads high
    '{1,1,0,0,1,12,0,0,1,0,0,10},
    '{1,1,1,0,1,12,0,0,1,0,0,10},
    '{1,0,1,0,1,12,0,0,1,0,1,9},   // R9 other master holds data low
    '{1,0,1,0,1,12,0,0,1,0,0,9},   // R9 no second pulse
    '{1,0,0,0,1,12,0,0,1,0,0,9},
    '{1,1,0,0,1,12,0,1,0,0,0,2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_ext = 1'b1, sda_ext = 1'b1;
  logic scl_dl = 1'b0, sda_dl = 1'b0, fast = 1'b0;
  logic scl_w, sda_w;
  logic start_pulse, stop_pulse, bus_busy, bus_free, arb_lost;
  int checks = 0, errors = 0;
  int n_s, n_p, n_a;
  logic done = 1'b0;

  assign scl_w = scl_ext & ~scl_dl;
  assign sda_w = sda_ext & ~sda_dl;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_monitor #(
    .FILT_LEN(FILT), .IDLE_STD_CYC(THR_STD), .IDLE_FAST_CYC(THR_FAST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .fast_mode(fast),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy),
    .bus_free(bus_free), .arb_lost(arb_lost)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int n);
    n_s = 0; n_p = 0; n_a = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      n_s += int'(start_pulse);
      n_p += int'(stop_pulse);
      n_a += int'(arb_lost);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "busy in reset", int'(bus_busy), 0);
    chk("R11", "free in reset", int'(bus_free), 0);
    chk("R11", "pulses in reset", int'(start_pulse | stop_pulse | arb_lost), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "free right after reset", int'(bus_free), 0);
    chk("R11", "busy right after reset", int'(bus_busy), 0);

    for (int v = 0; v < NV; v++) begin
      scl_ext = VECS[v].scl; sda_ext = VECS[v].sda;
      scl_dl = VECS[v].scl_dl; sda_dl = VECS[v].sda_dl; fast = VECS[v].fast;
      run(int'(VECS[v].hold));
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      chk(tag, "starts", n_s, int'(VECS[v].es));
      chk(tag, "stops", n_p, int'(VECS[v].ep));
      chk(tag, "arb", n_a, int'(VECS[v].ea));
      chk(tag, "busy", int'(bus_busy), int'(VECS[v].eb));
      chk(tag, "free", int'(bus_free), int'(VECS[v].ef));
    end

    // R8 two-cycle glitch ignored, three-cycle excursion accepted
    fast = 1'b0;
    run(50);
    sda_ext = 1'b0; run(FILT - 1); sda_ext = 1'b1; run(15);
    chk("R8", "short glitch starts", n_s, 0);
    chk("R8", "short glitch busy", int'(bus_busy), 0);
    sda_ext = 1'b0; run(FILT); sda_ext = 1'b1; run(15);
    chk("R8", "accepted pulse starts", n_s, 1);
    chk("R8", "accepted pulse stops", n_p, 1);

    // R7 clock-only low pulse restarts the idle count
    run(50);
    chk("R7", "free before clock pulse", int'(bus_free), 1);
    scl_ext = 1'b0; run(6);
    chk("R7", "free during clock low", int'(bus_free), 0);
    scl_ext = 1'b1; run(10);
    chk("R7", "free soon after", int'(bus_free), 0);
    chk("R4", "no condition on clock pulse", n_s + n_p, 0);
    run(40);
    chk("R7", "free after threshold", int'(bus_free), 1);

    // R11 reset while busy
    sda_ext = 1'b0; run(12);
    chk("R3", "busy before reset", int'(bus_busy), 1);
    rst_n = 1'b0; sda_ext = 1'b1; run(3);
    chk("R11", "busy cleared by reset", int'(bus_busy), 0);
    chk("R11", "free cleared by reset", int'(bus_free), 0);
    rst_n = 1'b1; run(12);
    chk("R11", "no start after reset release", n_s, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule